// File: doc/BRIEF.md
# Source-Synchronous DDR Input Frame Demultiplexer

This block receives a 24-line source-synchronous bus whose lines are sampled on both edges of the forwarded capture clock, so each line delivers two bits per clock period (160 Mbit/s per line at an 80 MHz capture clock). It gathers four consecutive bits per line into one 96-bit frame, which gives one frame every two capture clocks (a 40 MHz frame rate).

The block does not know where a frame begins. After start-up, the sender transmits a training pattern once. During that window the block tests every possible bit alignment in parallel. It commits to the first alignment that shows the pattern on all lines for a run of consecutive frames. The alignment is then frozen. Aligned frames are presented with a one-cycle strobe until reset or an explicit retrain request. A plain register stage downstream is expected to carry the frames into the system clock domain.

Top module: `ddr_frame_demux`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `locked`, `frame_stb` and `frame_o` are all zero.
- R2: Whenever `locked` is low, `frame_stb` is low and `frame_o` is all zero.
- R3: The training pattern on a line is the 4-bit sequence 1,0,0,0 in time order. It is recognised at any of the four bit offsets within the stream. `locked` rises once `LOCK_FRAMES` (default 8) consecutive frames at one offset show the pattern on every line.
- R4: Line i's four bits sit in `frame_o[4*i+3:4*i]`, with the earliest received bit in bit 4*i+3. Frames appear in the order they were sent, and none is skipped.
- R5: While locked, `frame_stb` pulses for one cycle out of every two, and it is never high on two adjacent cycles.
- R6: Once `locked` is high, it stays high and the chosen offset does not change, even if the input stream later shifts, until `retrain` or reset.
- R7: A `retrain` pulse clears `locked`, `frame_stb` and `frame_o` on the next cycle and restarts the search. The new search may settle on a different offset.
- R8: Any frame that does not match the training pattern restarts the consecutive count. A run shorter than `LOCK_FRAMES` therefore never sets `locked`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ddr | input | 1 | Forwarded capture clock; data is sampled on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| retrain | input | 1 | Synchronous request to drop lock and search again |
| din | input | LANES | Serial DDR data lines |
| frame_o | output | 4*LANES | Aligned frame; line i is in bits 4*i+3 down to 4*i |
| frame_stb | output | 1 | One-cycle strobe marking a new frame |
| locked | output | 1 | Alignment has been found and is held |

## Verification
If the frozen offset is wrong, it shows up on the very first strobed frame as nibbles that are rotated copies of the sent data. A shifted training stream is expected to give every nibble as 4, not 8. A broken consecutive count shows up as `locked` rising after an interrupted run that is too short. A phase counter that slips shows up within two cycles, as adjacent strobes or as skipped frames in the ordered comparison. A stale lock after `retrain` shows up on the next cycle as a non-zero frame or a high `locked`.

// File: rtl/ddr_demux_pkg.sv
package ddr_demux_pkg;
  localparam int unsigned FRAME_BITS = 4;
  localparam int unsigned HIST_BITS  = FRAME_BITS + 1;

  // Four-bit window out of a five-bit history (newest bit at index 0).
  function automatic logic [FRAME_BITS-1:0] pick_window(input logic [HIST_BITS-1:0] hist,
                                                        input logic shift);
    return shift ? hist[HIST_BITS-1:1] : hist[FRAME_BITS-1:0];
  endfunction

  // Lowest-numbered rotation among the hits.
  function automatic logic [1:0] first_hit(input logic [3:0] hits);
    logic [1:0] sel;
    sel = 2'd0;
    for (int r = 3; r >= 0; r--) begin
      if (hits[r]) sel = 2'(r);
    end
    return sel;
  endfunction
endpackage

// File: rtl/ddr_capture.sv
module ddr_capture
  import ddr_demux_pkg::*;
#(
  parameter int unsigned LANES = 24
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LANES-1:0]               din,
  output logic [LANES-1:0][HIST_BITS-1:0] hist
);
  logic [LANES-1:0] rise_q;
  logic [LANES-1:0] fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= din;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= din;
  end

  // Each rising edge appends the pair (earlier rise bit, later fall bit).
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist[l] <= '0;
      else        hist[l] <= {hist[l][HIST_BITS-3:0], rise_q[l], fall_q[l]};
    end
  end
endmodule

// File: rtl/align_search.sv
module align_search
  import ddr_demux_pkg::*;
#(
  parameter int unsigned LANES       = 24,
  parameter int unsigned LOCK_FRAMES = 8,
  parameter logic [3:0]  TRAIN_PAT   = 4'b1000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           retrain,
  input  logic [LANES-1:0][HIST_BITS-1:0] hist,
  output logic                           ph,
  output logic [3:0]                     hit_vec,
  output logic                           lock,
  output logic [1:0]                     rot_sel
);
  localparam int unsigned CW = $clog2(LOCK_FRAMES + 1);

  logic [3:0] win_ok;

  always_comb begin
    for (int r = 0; r < 4; r++) begin
      win_ok[r] = 1'b1;
      for (int l = 0; l < LANES; l++) begin
        if (pick_window(hist[l], 1'(r % 2)) != TRAIN_PAT) win_ok[r] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end

  for (genvar r = 0; r < 4; r++) begin : g_rot
    localparam logic RPH = 1'(r / 2);
    logic [CW-1:0] cnt;
    logic          slot;
    assign slot = (ph == RPH);
    assign hit_vec[r] = !lock && !retrain && slot && win_ok[r] && (cnt == CW'(LOCK_FRAMES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (retrain || lock) cnt <= '0;
      else if (slot)           cnt <= win_ok[r] ? ((cnt == CW'(LOCK_FRAMES - 1)) ? cnt : cnt + 1'b1)
                                                : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock    <= 1'b0;
      rot_sel <= 2'd0;
    end else if (retrain) begin
      lock    <= 1'b0;
    end else if (!lock && (|hit_vec)) begin
      lock    <= 1'b1;
      rot_sel <= first_hit(hit_vec);
    end
  end
endmodule

// File: rtl/frame_emit.sv
module frame_emit
  import ddr_demux_pkg::*;
#(
  parameter int unsigned LANES = 24
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           retrain,
  input  logic                           lock,
  input  logic [1:0]                     rot_sel,
  input  logic                           ph,
  input  logic [LANES-1:0][HIST_BITS-1:0] hist,
  output logic [FRAME_BITS*LANES-1:0]    frame,
  output logic                           strobe
);
  logic [FRAME_BITS*LANES-1:0] frame_nx;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      frame_nx[FRAME_BITS*l +: FRAME_BITS] = pick_window(hist[l], rot_sel[0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame  <= '0;
      strobe <= 1'b0;
    end else if (retrain || !lock) begin
      frame  <= '0;
      strobe <= 1'b0;
    end else if (ph == rot_sel[1]) begin
      frame  <= frame_nx;
      strobe <= 1'b1;
    end else begin
      strobe <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr_frame_demux.sv
module ddr_frame_demux
  import ddr_demux_pkg::*;
#(
  parameter int unsigned LANES       = 24,
  parameter int unsigned LOCK_FRAMES = 8
) (
  input  logic                        clk_ddr,
  input  logic                        rst_n,
  input  logic                        retrain,
  input  logic [LANES-1:0]            din,
  output logic [FRAME_BITS*LANES-1:0] frame_o,
  output logic                        frame_stb,
  output logic                        locked
);
  logic [LANES-1:0][HIST_BITS-1:0] hist;
  logic                            ph;
  logic [3:0]                      hit_vec;
  logic [1:0]                      rot_sel;

  ddr_capture #(.LANES(LANES)) cap_i (
    .clk(clk_ddr), .rst_n(rst_n), .din(din), .hist(hist)
  );

  align_search #(.LANES(LANES), .LOCK_FRAMES(LOCK_FRAMES)) srch_i (
    .clk(clk_ddr), .rst_n(rst_n), .retrain(retrain), .hist(hist),
    .ph(ph), .hit_vec(hit_vec), .lock(locked), .rot_sel(rot_sel)
  );

  frame_emit #(.LANES(LANES)) emit_i (
    .clk(clk_ddr), .rst_n(rst_n), .retrain(retrain), .lock(locked),
    .rot_sel(rot_sel), .ph(ph), .hist(hist), .frame(frame_o), .strobe(frame_stb)
  );
endmodule

// File: rtl/ddr_demux_checker.sv
module ddr_demux_checker #(
  parameter int unsigned LANES = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               retrain,
  input logic               locked,
  input logic               frame_stb,
  input logic [4*LANES-1:0] frame_o,
  input logic [1:0]         rot_sel,
  input logic [3:0]         hit_vec
);
  assert_strobe_needs_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> locked);

  assert_zero_frame_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (frame_o == '0));

  assert_no_adjacent_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb);

  assert_lock_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !retrain) |=> (locked && $stable(rot_sel)));

  assert_retrain_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    retrain |=> (!locked && !frame_stb));

  assert_hit_sets_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> locked);
endmodule

bind ddr_frame_demux ddr_demux_checker #(.LANES(LANES)) chk_i (
  .clk(clk_ddr), .rst_n(rst_n), .retrain(retrain), .locked(locked),
  .frame_stb(frame_stb), .frame_o(frame_o), .rot_sel(rot_sel), .hit_vec(hit_vec)
);

// File: tb/ddr_frame_demux_tb_top.sv
`timescale 1ns/1ps
module ddr_frame_demux_tb_top;
  localparam int LANES = 24;
  localparam int FW    = 4 * LANES;
  localparam logic [FW-1:0] ALL8 = {LANES{4'h8}};
  localparam logic [FW-1:0] ALL4 = {LANES{4'h4}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retrain = 1'b0;
  logic [LANES-1:0] din = '0;
  logic [FW-1:0] frame_o;
  logic frame_stb;
  logic locked;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit par = 1'b0;
  logic [FW-1:0] exp_q [0:31];
  int n_data = 0;
  int ptr = 0;
  logic prev_stb = 1'b0;

  always #2.5 clk = ~clk;

  ddr_frame_demux #(.LANES(LANES)) dut_i (
    .clk_ddr(clk), .rst_n(rst_n), .retrain(retrain), .din(din),
    .frame_o(frame_o), .frame_stb(frame_stb), .locked(locked)
  );

  task automatic check(input bit ok, input string req, input logic [FW-1:0] act,
                       input logic [FW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Bench restatement of the frame layout: nibble i MSB is the first bit in time.
  function automatic logic [LANES-1:0] bit_of(input logic [FW-1:0] f, input int b);
    logic [LANES-1:0] v;
    for (int l = 0; l < LANES; l++) v[l] = f[4*l + 3 - b];
    return v;
  endfunction

  function automatic logic [FW-1:0] rand_frame();
    logic [FW-1:0] f;
    for (int w = 0; w < FW; w += 32) f[w +: 32] = $urandom;
    return f;
  endfunction

  task automatic put(input logic [LANES-1:0] v);
    if (!par) @(negedge clk); else @(posedge clk);
    #1 din = v;
    par = ~par;
  endtask

  task automatic send_frame(input logic [FW-1:0] f);
    for (int b = 0; b < 4; b++) put(bit_of(f, b));
  endtask

  task automatic pad(input int n);
    for (int i = 0; i < n; i++) put('0);
  endtask

  // Ordered comparison of strobed frames (R4, R5).
  always @(posedge clk) begin
    #2;
    if (frame_stb) begin
      check(!prev_stb, "R5 adjacent strobes", {95'd0, prev_stb}, '0);
      if (ptr < n_data) begin
        if (frame_o == exp_q[ptr]) ptr++;
        else check(ptr == 0 && frame_o == ALL8, "R4 frame order/content", frame_o,
                   (ptr == 0) ? ALL8 : exp_q[ptr]);
      end
    end
    prev_stb = frame_stb;
  end

  task automatic data_run(input int padbits, input int n);
    n_data = 0; ptr = 0;
    for (int i = 0; i < n; i++) exp_q[i] = rand_frame();
    n_data = n;
    pad(padbits);
    for (int i = 0; i < 12; i++) send_frame(ALL8);
    check(locked === 1'b1, "R3 lock after training", {95'd0, locked}, 1);
    for (int i = 0; i < n; i++) send_frame(exp_q[i]);
    for (int i = 0; i < 3; i++) send_frame('0);
    check(ptr == n, "R4 all data frames seen", FW'(ptr), FW'(n));
  endtask

  task automatic pulse_retrain();
    @(posedge clk); #1 retrain = 1'b1;
    @(posedge clk); #1 retrain = 1'b0;
    #1;
    check(locked == 1'b0 && frame_stb == 1'b0, "R7 retrain clears lock", {94'd0, locked, frame_stb}, '0);
    check(frame_o == '0, "R7 retrain clears frame", frame_o, '0);
    par = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check(locked == 0 && frame_stb == 0 && frame_o == '0, "R1 in reset", frame_o, '0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check(locked == 0 && frame_stb == 0 && frame_o == '0, "R1 after reset", frame_o, '0);

    // R8: interrupted run, then a short run, must not lock
    pad(1);
    for (int i = 0; i < 5; i++) send_frame(ALL8);
    send_frame('0);
    for (int i = 0; i < 7; i++) send_frame(ALL8);
    for (int i = 0; i < 3; i++) send_frame('0);
    check(locked == 1'b0, "R8 short run no lock", {95'd0, locked}, '0);
    check(frame_stb == 0 && frame_o == '0, "R2 idle while unlocked", frame_o, '0);

    // R3/R4 lock and ordered data at offset 1
    data_run(0, 20);

    // R6: stream slips by one bit; lock and offset must hold
    pad(1);
    for (int i = 0; i < 10; i++) send_frame(ALL8);
    check(locked == 1'b1, "R6 lock held after slip", {95'd0, locked}, 1);
    check(frame_o == ALL4, "R6 offset frozen", frame_o, ALL4);

    // R7: retrain and find new offsets
    pulse_retrain();
    data_run(2, 16);
    pulse_retrain();
    data_run(3, 16);
    pulse_retrain();
    data_run(0, 12);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule